// File: doc/BRIEF.md
# Inter-Layer Test Data Serial Link

This block moves the parallel tap outputs of a test decompressor from one die layer to the layer above over fewer vertical wires. The wires run on the fast functional clock, which is `RATIO` times the scan shift rate. Each wire therefore carries `RATIO` bits per scan period, and the link needs only `ceil(TAP_W / RATIO)` wires instead of `TAP_W`.

The sending side registers its `TAP_W`-bit word when the scan-rate strobe is high. In the `RATIO` fast cycles that follow, it puts the word onto the link one `LINK_W`-bit slice at a time, lowest slice first. The receiving side shifts every link slice into a register that is `RATIO` words deep. On the next strobe it loads the reassembled word into its parallel output, and that output feeds the receiving decompressor.

The whole block runs on one clock. The scan rate is a strobe that is high for one fast cycle in every `RATIO` cycles. Any padding bits in the last slice are sent as zero and dropped on arrival.

Top module: `layer_link_top`

## Requirements
- R1: The link is `ceil(TAP_W/RATIO)` wires wide (4 wires for TAP_W=16 or TAP_W=14 with RATIO=4), and a full input word crosses it intact within one scan period.
- R2: While `rst_n` is low at a clock edge, both `link` and `par_out` become zero, and the first strobe after reset presents zero on `par_out`.
- R3: In fast cycle k after a strobe edge (k = 0 for the cycle right after that edge), `link` carries bits `k*LINK_W` to `k*LINK_W+LINK_W-1` of the word that `par_in` held at the strobe edge.
- R4: Changes on `par_in` in cycles without a strobe have no effect on `link` or on `par_out`.
- R5: At each strobe edge, `par_out` takes the word that `par_in` held at the previous strobe edge, with slice 0 in the lowest bits. It then stays unchanged until the next strobe edge.
- R6: When TAP_W is not a multiple of the link width, the unused upper bits of the last slice are driven as zero on `link` and never reach `par_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_stb | input | 1 | Scan-rate strobe, one cycle high every RATIO cycles |
| par_in | input | TAP_W | Decompressor tap bits from the sending layer |
| link | output | LINK_W | Serial slices on the vertical wires |
| par_out | output | TAP_W | Reassembled bits for the receiving decompressor |

## Verification
Slice k of a word appears on `link` in the fast cycle that follows the k-th edge after the strobe edge that sampled the word. That word reaches `par_out` exactly at the next strobe edge, one scan period (RATIO cycles) later, and `par_out` then holds for RATIO cycles. The bench drives its inputs on falling edges and reads outputs on falling edges, so each check looks at the value registered at the rising edge just before it. It checks every slice in its own cycle and checks `par_out` against the previous period's word in all four cycles of the current period.

// File: rtl/lnk_pkg.sv
// Package: shared helpers for the inter-layer serial link.
// Assumes: ratio is at least 1.
package lnk_pkg;

    // Number of link wires needed to move m bits in n fast cycles.
    function automatic int link_width(input int m, input int n);
        return (m + n - 1) / n;
    endfunction

    // Width of a select able to index n slices.
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lnk_phase_ctr.sv
// Module: slice phase counter for the serializer.
// Does: restarts at slice 0 on the strobe edge and advances once per fast
// cycle, wrapping after RATIO-1.
// Assumes: the strobe recurs every RATIO cycles, so no wrap happens in normal use.
module lnk_phase_ctr #(
    parameter int RATIO = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_stb,
    output logic [SEL_W-1:0] sel
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(RATIO - 1);

    logic [SEL_W-1:0] sel_q;

    // Phase register: cleared by reset or strobe, otherwise counts with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || scan_stb) begin
            sel_q <= '0;
        end else if (sel_q == LAST) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_q + 1'b1;
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/lnk_serializer.sv
// Module: sending side of the link.
// Does: registers the tap word on the strobe, padded with zeros to
// LINK_W*RATIO bits, and drives the slice picked by sel onto the wires.
// Assumes: sel comes from lnk_phase_ctr and stays below RATIO.
module lnk_serializer #(
    parameter int TAP_W  = 16,
    parameter int RATIO  = 4,
    parameter int LINK_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_stb,
    input  logic [TAP_W-1:0]  par_in,
    input  logic [SEL_W-1:0]  sel,
    output logic [LINK_W-1:0] link
);
    localparam int PAD_W = LINK_W * RATIO;

    logic [PAD_W-1:0]  hold_q;
    logic [LINK_W-1:0] slice_a [RATIO];

    // Hold register: takes the zero-padded tap word on the strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (scan_stb) begin
            hold_q <= PAD_W'(par_in);
        end
    end

    // Cut the held word into RATIO slices, lowest slice first.
    for (genvar g = 0; g < RATIO; g++) begin : g_slice
        assign slice_a[g] = hold_q[g*LINK_W +: LINK_W];
    end

    // Slice multiplexer onto the vertical wires.
    always_comb begin
        link = '0;
        for (int i = 0; i < RATIO; i++) begin
            if (sel == SEL_W'(i)) begin
                link = slice_a[i];
            end
        end
    end
endmodule

// File: rtl/lnk_deserializer.sv
// Module: receiving side of the link.
// Does: shifts each incoming slice into a RATIO-deep word shift register,
// entering at the top, and on the strobe loads the completed word (including
// the slice arriving that cycle) into the parallel output.
// Assumes: the strobe marks the last slice cycle of each period; padding bits
// sit at the top of the last slice and are dropped.
module lnk_deserializer #(
    parameter int TAP_W  = 16,
    parameter int RATIO  = 4,
    parameter int LINK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_stb,
    input  logic [LINK_W-1:0] link,
    output logic [TAP_W-1:0]  par_out
);
    logic [LINK_W-1:0] shift_q [RATIO];
    logic [LINK_W-1:0] nxt_a   [RATIO];
    logic [TAP_W-1:0]  word_w;
    logic [TAP_W-1:0]  out_q;

    // Next shift state: each word moves one place down, the new slice enters at the top.
    for (genvar g = 0; g < RATIO; g++) begin : g_nxt
        if (g == RATIO - 1) begin : g_top
            assign nxt_a[g] = link;
        end else begin : g_mid
            assign nxt_a[g] = shift_q[g+1];
        end
    end

    // Flatten the next state into the output word, keeping only real tap bits.
    for (genvar b = 0; b < TAP_W; b++) begin : g_flat
        assign word_w[b] = nxt_a[b / LINK_W][b % LINK_W];
    end

    // Shift register: moves on every fast clock edge.
    always_ff @(posedge clk) begin
        for (int i = 0; i < RATIO; i++) begin
            if (!rst_n) begin
                shift_q[i] <= '0;
            end else begin
                shift_q[i] <= nxt_a[i];
            end
        end
    end

    // Parallel output register: loaded at scan rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (scan_stb) begin
            out_q <= word_w;
        end
    end

    assign par_out = out_q;
endmodule

// File: rtl/layer_link_top.sv
// Module: inter-layer serial link, sending and receiving sides joined.
// Does: carries TAP_W tap bits per scan period over ceil(TAP_W/RATIO) wires,
// with one scan period of latency from par_in to par_out.
// Assumes: a single fast clock; scan_stb is high for one cycle every RATIO cycles.
module layer_link_top #(
    parameter int TAP_W = 16,
    parameter int RATIO = 4,
    localparam int LINK_W = lnk_pkg::link_width(TAP_W, RATIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_stb,
    input  logic [TAP_W-1:0]  par_in,
    output logic [LINK_W-1:0] link,
    output logic [TAP_W-1:0]  par_out
);
    localparam int SEL_W = lnk_pkg::sel_width(RATIO);

    logic [SEL_W-1:0]  sel_w;
    logic [LINK_W-1:0] wire_w;

    lnk_phase_ctr #(.RATIO(RATIO), .SEL_W(SEL_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_stb (scan_stb),
        .sel      (sel_w)
    );

    lnk_serializer #(.TAP_W(TAP_W), .RATIO(RATIO), .LINK_W(LINK_W), .SEL_W(SEL_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_stb (scan_stb),
        .par_in   (par_in),
        .sel      (sel_w),
        .link     (wire_w)
    );

    lnk_deserializer #(.TAP_W(TAP_W), .RATIO(RATIO), .LINK_W(LINK_W)) u_des (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_stb (scan_stb),
        .link     (wire_w),
        .par_out  (par_out)
    );

    assign link = wire_w;
endmodule

// File: rtl/layer_link_chk.sv
// Module: protocol checker bound to layer_link_top.
// Does: keeps its own copy of the word sampled at each strobe and a phase
// count, and checks slice order, latency, hold and padding against them.
module layer_link_chk #(
    parameter int TAP_W = 16,
    parameter int RATIO = 4
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic                                        scan_stb,
    input logic [TAP_W-1:0]                            par_in,
    input logic [lnk_pkg::link_width(TAP_W,RATIO)-1:0] link,
    input logic [TAP_W-1:0]                            par_out
);
    localparam int LINK_W = lnk_pkg::link_width(TAP_W, RATIO);
    localparam int PAD_W  = LINK_W * RATIO;
    localparam int PH_W   = $clog2(RATIO + 1);

    logic [PAD_W-1:0] cur_q;
    logic [PH_W-1:0]  ph_q;
    logic             seen_q;

    // Model state: word at last strobe, cycles since it, and whether a strobe occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            ph_q   <= '0;
            seen_q <= 1'b0;
        end else if (scan_stb) begin
            cur_q  <= PAD_W'(par_in);
            ph_q   <= '0;
            seen_q <= 1'b1;
        end else if (ph_q < PH_W'(RATIO)) begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // R2: outputs are zero right after reset.
    p_reset_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (link == '0 && par_out == '0));

    // R3: slice k of the sampled word is on the link in cycle k.
    p_slice_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ph_q < PH_W'(RATIO)) |-> (link == cur_q[ph_q*LINK_W +: LINK_W]));

    // R5: output loads the previous strobe's word.
    p_roundtrip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && scan_stb) |=> (par_out == $past(cur_q[TAP_W-1:0])));

    // R4: output holds between strobes.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_stb |=> $stable(par_out));

    if (PAD_W > TAP_W) begin : g_pad
        // R6: padding wires stay zero in the last slice.
        p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && ph_q == PH_W'(RATIO - 1)) |-> (link[LINK_W-1 -: PAD_W-TAP_W] == '0));
    end
endmodule

bind layer_link_top layer_link_chk #(.TAP_W(TAP_W), .RATIO(RATIO)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_stb (scan_stb),
    .par_in   (par_in),
    .link     (link),
    .par_out  (par_out)
);

// File: tb/tb_layer_link_top.sv
module tb_layer_link_top;
    localparam int NV = 8;
    typedef struct packed {
        logic [15:0] stim;
        logic [15:0] exp_out;
    } vec_t;
    localparam vec_t VECS [NV] = '{
        '{16'hA5C3, 16'h0000}, '{16'h0001, 16'hA5C3},
        '{16'h8000, 16'h0001}, '{16'hFFFF, 16'h8000},
        '{16'h0000, 16'hFFFF}, '{16'h1234, 16'h0000},
        '{16'hF00F, 16'h1234}, '{16'h5A5A, 16'hF00F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_stb = 1'b0;
    logic [15:0] par_in = '0;
    logic [3:0]  link;
    logic [15:0] par_out;
    logic [3:0]  link_p;
    logic [13:0] par_out_p;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    layer_link_top #(.TAP_W(16), .RATIO(4)) dut (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb),
        .par_in(par_in), .link(link), .par_out(par_out));

    layer_link_top #(.TAP_W(14), .RATIO(4)) dut_pad (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb),
        .par_in(par_in[13:0]), .link(link_p), .par_out(par_out_p));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One scan period, entered and left on a falling edge.
    task automatic period(input logic [15:0] v, input logic [15:0] prev);
        logic [15:0] pv;
        pv = {2'b00, v[13:0]};
        scan_stb = 1'b1;
        par_in = v;
        @(negedge clk);
        scan_stb = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            check("R3 R4 slice", 32'(link), 32'(v[k*4 +: 4]));
            check("R5 R4 hold", 32'(par_out), 32'(prev));
            check("R1 R6 pad slice", 32'(link_p), 32'(pv[k*4 +: 4]));
            check("R1 R6 pad out", 32'(par_out_p), 32'(prev[13:0]));
            par_in = 16'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] prev;
        logic [15:0] v;
        // R2: reset state.
        repeat (3) @(negedge clk);
        check("R2 reset link", 32'(link), 32'h0);
        check("R2 reset out", 32'(par_out), 32'h0);
        rst_n = 1'b1;
        // Table walk: R3, R4, R5, and R1/R6 on the padded instance.
        for (int i = 0; i < NV; i++) begin
            period(VECS[i].stim, VECS[i].exp_out);
        end
        // R5: random round trips.
        prev = VECS[NV-1].stim;
        for (int i = 0; i < 40; i++) begin
            v = 16'($urandom);
            period(v, prev);
            prev = v;
        end
        // R2: reset mid-run clears outputs; next strobe shows zero.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 midrun link", 32'(link), 32'h0);
        check("R2 midrun out", 32'(par_out), 32'h0);
        check("R2 midrun pad out", 32'(par_out_p), 32'h0);
        rst_n = 1'b1;
        period(16'hC001, 16'h0000);
        period(16'h3FFF, 16'hC001);
        // R6: all-ones word keeps the pad wires low and drops them on arrival.
        period(16'h0000, 16'h3FFF);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule